// File: doc/BRIEF.md
# GPIO Edge Event Mapper

The block watches 32 already-synchronized GPIO input levels. A rise or a fall seen between two consecutive clock samples of a pin sets that pin's bit in a sticky rising-status or falling-status word. The bit stays set until software writes a 1 to it. Software gives each pin a small routing field, and the field sends that pin's pending edges to one of eight event pairs. The same field can also mark the pin as a wake source.

A separate select word gives each event pair an interrupt line number from 0 to 15, where 0 means the pair drives no line. An interrupt line stays high while any pin routed to a pair that selects it has an edge pending. The power-management flag stays high while any pin marked as a wake source has an edge pending. All registers sit on a plain single-cycle write bus with a combinational read port.

Top module: `gpio_event_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, all routing words, the select word, both status words and the stored previous pin levels become 0. After that, `irq_out` and `pme_out` are low and every register reads 0.
- R2: Pin i sampled 0 at one rising clock edge and 1 at the next sets bit i of the rising-status word at that second edge. A 1-to-0 change sets bit i of the falling-status word in the same way. The first sample after reset is compared with a level of 0.
- R3: A write to address 4 (rising status) or address 5 (falling status) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an edge on a pin and a write-1-clear of that same status bit fall in the same cycle, the bit ends up set.
- R5: Routing words sit at addresses 0 to 3. Word a covers pins 8a to 8a+7. Pin i uses bits [4(i mod 8)+3 : 4(i mod 8)] of its word. The low 3 bits of that field give the event pair (0 to 7), and bit 3 marks the pin as a wake source.
- R6: The select word sits at address 6. Bits [4g+3:4g] give the line number for event pair g. `irq_out[n]` is high while some pin with either status bit set is routed to a pair whose line number is n.
- R7: A line number of 0 routes the pair nowhere, so `irq_out[0]` is never asserted.
- R8: `pme_out` is high exactly while some pin whose field has bit 3 set has either status bit set.
- R9: `bus_rdata` shows the register at `bus_addr` in the same cycle. A write takes effect at the next clock edge. Address 7 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 32 | Synchronized GPIO input levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 16 | Interrupt request lines |
| pme_out | output | 1 | Power-management event flag |

## Verification
Single-pin rises and falls are checked against the two status words. This separates the two edge directions and shows that the other pins stay clear. Clears are written with all-zero masks, with partial masks, and in the same cycle as a new edge on the same bit. These patterns separate a write-1-clear from a plain overwrite and confirm that a new edge wins over a clear.

Several routing cases are driven and checked:
- a pin in the middle of its group, which confirms the field position;
- a pair whose select field is 0, which must stay silent;
- two pins that share one pair, where clearing one of them must leave the line high;
- a wake-only pin, which must raise the power flag and no line.

A long random run then mixes pin toggles with writes to every address, including the unused one. That run is checked each cycle against a behavioural model.

// File: rtl/gem_pkg.sv
package gem_pkg;
    localparam int NPINS    = 32;
    localparam int GRP_PINS = 8;
    localparam int NGROUPS  = NPINS / GRP_PINS;
    localparam int GSEL_W   = $clog2(NGROUPS);
    localparam int FLD_W    = 4;
    localparam int NPAIRS   = 8;
    localparam int PAIR_W   = $clog2(NPAIRS);
    localparam int NIRQ     = 16;
    localparam int IRQ_W    = $clog2(NIRQ);
    localparam int DW       = 32;
    localparam int AW       = 3;

    localparam logic [AW-1:0] A_RISE = 3'd4;
    localparam logic [AW-1:0] A_FALL = 3'd5;
    localparam logic [AW-1:0] A_ISEL = 3'd6;

    typedef logic [DW-1:0] word_t;
    typedef logic [NGROUPS-1:0][DW-1:0] map_bank_t;

    typedef struct packed {
        logic              pme;
        logic [PAIR_W-1:0] pair;
    } map_fld_t;

    typedef enum logic [2:0] {
        RG_MAP,
        RG_RISE,
        RG_FALL,
        RG_ISEL,
        RG_NONE
    } reg_sel_e;

    function automatic reg_sel_e reg_decode(logic [AW-1:0] a);
        if (int'(a) < NGROUPS) return RG_MAP;
        else if (a == A_RISE)  return RG_RISE;
        else if (a == A_FALL)  return RG_FALL;
        else if (a == A_ISEL)  return RG_ISEL;
        else                   return RG_NONE;
    endfunction

    function automatic map_fld_t pin_field(map_bank_t b, int pin);
        return map_fld_t'(b[pin / GRP_PINS][FLD_W * (pin % GRP_PINS) +: FLD_W]);
    endfunction

    function automatic logic [IRQ_W-1:0] pair_irq(word_t sel, int p);
        return sel[FLD_W * p +: IRQ_W];
    endfunction
endpackage

// File: rtl/gem_cfg_regs.sv
module gem_cfg_regs
    import gem_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output map_bank_t     map_bank,
    output word_t         isel
);
    reg_sel_e dec;
    assign dec = reg_decode(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            map_bank <= '0;
            isel     <= '0;
        end else if (we) begin
            for (int g = 0; g < NGROUPS; g++) begin
                if (dec == RG_MAP && addr[GSEL_W-1:0] == GSEL_W'(g))
                    map_bank[g] <= wdata;
            end
            if (dec == RG_ISEL)
                isel <= wdata;
        end
    end

    // R9: a select-word write lands at the next edge
    a_r9_isel_write: assert property (@(posedge clk) disable iff (rst)
        (we && dec == RG_ISEL) |=> (isel == $past(wdata)));
endmodule

// File: rtl/gem_edge_latch.sv
module gem_edge_latch
    import gem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] clr_rise,
    input  logic [NPINS-1:0] clr_fall,
    output logic [NPINS-1:0] rise_sts,
    output logic [NPINS-1:0] fall_sts
);
    logic [NPINS-1:0] prev_lvl;
    logic [NPINS-1:0] rise_ev;
    logic [NPINS-1:0] fall_ev;

    assign rise_ev = pin_lvl & ~prev_lvl;
    assign fall_ev = ~pin_lvl & prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= '0;
            rise_sts <= '0;
            fall_sts <= '0;
        end else begin
            prev_lvl <= pin_lvl;
            rise_sts <= rise_ev | (rise_sts & ~clr_rise);
            fall_sts <= fall_ev | (fall_sts & ~clr_fall);
        end
    end

    // R1: reset empties both status words
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (rise_sts == '0 && fall_sts == '0));
    // R2: every detected edge is latched
    a_r2_rise_latched: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((rise_sts & $past(rise_ev)) == $past(rise_ev)));
    a_r2_fall_latched: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((fall_sts & $past(fall_ev)) == $past(fall_ev)));
    // R3: cleared bits without a new edge drop
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((rise_sts & $past(clr_rise & ~rise_ev)) == '0 &&
                  (fall_sts & $past(clr_fall & ~fall_ev)) == '0));
    // R3: bits neither cleared nor hit by an edge keep their value
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((rise_sts ^ $past(rise_sts)) & ~$past(rise_ev | clr_rise)) == '0));
    // R4: an edge beats a same-cycle clear
    a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((rise_sts & $past(rise_ev & clr_rise)) == $past(rise_ev & clr_rise)));
endmodule

// File: rtl/gem_router.sv
module gem_router
    import gem_pkg::*;
(
    input  map_bank_t        map_bank,
    input  word_t            isel,
    input  logic [NPINS-1:0] pending,
    output logic [NIRQ-1:0]  irq,
    output logic             pme
);
    logic [NPAIRS-1:0] pair_act;

    always_comb begin
        map_fld_t f;
        pair_act = '0;
        pme      = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            f = pin_field(map_bank, i);
            if (pending[i]) begin
                pair_act[f.pair] = 1'b1;
                pme = pme | f.pme;
            end
        end
    end

    always_comb begin
        logic [IRQ_W-1:0] n;
        irq = '0;
        for (int p = 0; p < NPAIRS; p++) begin
            n = pair_irq(isel, p);
            if (pair_act[p] && n != '0)
                irq[n] = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_event_mapper.sv
module gpio_event_mapper
    import gem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic [NIRQ-1:0]  irq_out,
    output logic             pme_out
);
    map_bank_t        map_bank;
    word_t            isel;
    logic [NPINS-1:0] rise_sts, fall_sts, clr_rise, clr_fall;
    reg_sel_e         dec;

    assign dec      = reg_decode(bus_addr);
    assign clr_rise = (bus_we && dec == RG_RISE) ? bus_wdata : '0;
    assign clr_fall = (bus_we && dec == RG_FALL) ? bus_wdata : '0;

    gem_cfg_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .map_bank(map_bank), .isel(isel)
    );

    gem_edge_latch u_edge (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl),
        .clr_rise(clr_rise), .clr_fall(clr_fall),
        .rise_sts(rise_sts), .fall_sts(fall_sts)
    );

    gem_router u_route (
        .map_bank(map_bank), .isel(isel), .pending(rise_sts | fall_sts),
        .irq(irq_out), .pme(pme_out)
    );

    always_comb begin
        case (dec)
            RG_MAP:  bus_rdata = map_bank[bus_addr[GSEL_W-1:0]];
            RG_RISE: bus_rdata = rise_sts;
            RG_FALL: bus_rdata = fall_sts;
            RG_ISEL: bus_rdata = isel;
            default: bus_rdata = '0;
        endcase
    end

    // R7: line 0 is never driven
    a_r7_irq0_quiet: assert property (@(posedge clk) disable iff (rst)
        !irq_out[0]);
    // R6: a raised line needs a pending edge
    a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |-> ((rise_sts | fall_sts) != '0));
    // R8: the wake flag needs a pending edge
    a_r8_pme_needs_pending: assert property (@(posedge clk) disable iff (rst)
        pme_out |-> ((rise_sts | fall_sts) != '0));
endmodule

// File: tb/gpio_event_mapper_tb.sv
module gpio_event_mapper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_lvl = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;
    logic        pme_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    gpio_event_mapper u_dut (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .pme_out(pme_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference model
    bit [31:0] m_map [4];
    bit [31:0] m_sel, m_pos, m_neg, m_prev;

    always @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < 4; g++) m_map[g] = 0;
            m_sel = 0; m_pos = 0; m_neg = 0; m_prev = 0;
        end else begin
            bit [31:0] cp, cn;
            cp = (bus_we && bus_addr == 4) ? bus_wdata : 0;
            cn = (bus_we && bus_addr == 5) ? bus_wdata : 0;
            m_pos = (pin_lvl & ~m_prev) | (m_pos & ~cp);
            m_neg = (~pin_lvl & m_prev) | (m_neg & ~cn);
            m_prev = pin_lvl;
            if (bus_we && bus_addr < 4) m_map[bus_addr] = bus_wdata;
            if (bus_we && bus_addr == 6) m_sel = bus_wdata;
        end
    end

    function automatic bit [31:0] m_read(int a);
        if (a < 4) return m_map[a];
        if (a == 4) return m_pos;
        if (a == 5) return m_neg;
        if (a == 6) return m_sel;
        return 0;
    endfunction

    function automatic bit [16:0] m_outs();
        bit [15:0] irq = 0;
        bit pme = 0;
        for (int i = 0; i < 32; i++) begin
            int f, n;
            f = (m_map[i / 8] >> (4 * (i % 8))) & 15;
            if (((m_pos | m_neg) >> i) & 1) begin
                if (f & 8) pme = 1;
                n = (m_sel >> (4 * (f & 7))) & 15;
                if (n != 0) irq[n] = 1;
            end
        end
        return {pme, irq};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of the interrupt outputs with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit [16:0] e;
            e = m_outs();
            check("R6/R8 model irq", {16'h0, irq_out}, {16'h0, e[15:0]});
            check("R8 model pme", {31'h0, pme_out}, {31'h0, e[16]});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic pins(logic [31:0] v);
        @(negedge clk);
        pin_lvl = v;
        @(negedge clk);
    endtask

    task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic clear_all();
        pins(0);
        wr(4, 32'hFFFF_FFFF);
        wr(5, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {16'h0, irq_out}, 0);
        check("R1 pme", {31'h0, pme_out}, 0);
        for (int a = 0; a < 8; a++) rd("R1 reg", a[2:0], 0);

        // R2 rise then fall on pin 5
        pins(32'h20);
        rd("R2 rise", 4, 32'h20);
        rd("R2 no fall", 5, 0);
        pins(0);
        rd("R2 fall", 5, 32'h20);

        // R3 write zero keeps, write one clears
        wr(4, 0);
        rd("R3 zero keeps", 4, 32'h20);
        wr(4, 32'h0000_0021);
        rd("R3 one clears", 4, 0);
        rd("R3 other word untouched", 5, 32'h20);
        wr(5, 32'hFFFF_FFFF);
        rd("R3 fall cleared", 5, 0);

        // R4 edge and clear in one cycle
        @(negedge clk);
        pin_lvl = 32'h80; bus_we = 1; bus_addr = 4; bus_wdata = 32'h80;
        @(negedge clk);
        bus_we = 0;
        rd("R4 set wins", 4, 32'h80);
        clear_all();

        // R5/R6 pin 13 -> pair 3 -> line 9
        wr(1, 32'h0030_0000);
        wr(6, 32'h0000_9000);
        rd("R9 map readback", 1, 32'h0030_0000);
        rd("R9 sel readback", 6, 32'h0000_9000);
        pins(32'h2000);
        check("R5 pin13 routes to line 9", {16'h0, irq_out}, 32'h200);
        check("R5 no pme", {31'h0, pme_out}, 0);
        // R7 pin 12 -> pair 0 whose line is 0
        pins(32'h3000);
        wr(4, 32'h2000);
        rd("R7 pin12 pending", 4, 32'h1000);
        check("R7 zero line silent", {16'h0, irq_out}, 0);
        clear_all();

        // R8 pin 30 wake-only
        wr(3, 32'h0800_0000);
        pins(32'h4000_0000);
        check("R8 pme raised", {31'h0, pme_out}, 1);
        check("R8 no line", {16'h0, irq_out}, 0);
        wr(4, 32'h4000_0000);
        check("R8 pme drops", {31'h0, pme_out}, 0);
        clear_all();

        // R6 two pins share pair 2 -> line 15
        wr(0, 32'h0000_0022);
        wr(6, 32'h0000_9F00);
        pins(32'h3);
        check("R6 shared line", {16'h0, irq_out}, 32'h8000);
        wr(4, 32'h1);
        check("R6 line held by pin1", {16'h0, irq_out}, 32'h8000);
        wr(4, 32'h2);
        check("R6 line released", {16'h0, irq_out}, 0);

        // R9 address 7 ignored
        wr(7, 32'hFFFF_FFFF);
        rd("R9 addr7 reads zero", 7, 0);
        rd("R9 map0 kept", 0, 32'h0000_0022);
        rd("R9 map3 kept", 3, 32'h0800_0000);
        rd("R9 sel kept", 6, 32'h0000_9F00);

        // random mix, compared with the model
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            pin_lvl = ($urandom % 4 == 0) ? $urandom : pin_lvl;
            bus_we = ($urandom % 3 == 0);
            bus_addr = 3'($urandom);
            bus_wdata = $urandom;
            #1;
            check("R9 random read", bus_rdata, m_read(int'(bus_addr)));
        end
        @(negedge clk);
        bus_we = 0;
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule